// File: doc/BRIEF.md
# Augmented Parallel Hammerstein Predistorter

A streaming complex baseband predistorter that sits in front of a transmit power amplifier. Every accepted I/Q sample is expanded into odd-order polynomial basis terms. Three of these terms come from the sample itself and two come from its complex conjugate. Each basis stream runs through its own five-tap complex FIR filter. The five filter outputs are added together with one constant complex offset, which cancels local-oscillator leakage. The result is rounded and saturated to a 16-bit I/Q output. Amplifier nonlinearity and I/Q imbalance are therefore corrected in one shared datapath.

Coefficients are loaded through a one-cycle register-write port. A write goes into a staging copy. The staging copy is moved into the working copy only when no sample is inside the pipeline. While an update is waiting, input acceptance stops so that the pipeline can empty. Each output sample is therefore computed from exactly one coefficient set.

Top module: `aph_predistorter`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high, and every coefficient and history value is zero.
- R2: Main branch b (b = 0, 1, 2; order 1, 3, 5) uses the gain s = (sum over j <= b of w[b][j]*e[j]) >>> 12. Here e[0] = 32768, e[1] = (I*I + Q*Q) >>> 15, and e[2] = (e[1]*e[1]) >>> 15. Its basis value is ((s*I) >>> 15, (s*Q) >>> 15).
- R3: Conjugate branches b = 3 and b = 4 (order 1 and 3) use weight rows up to j = b-3. Their basis value is formed from (I, -Q).
- R4: Each branch filter output is the sum over k = 0..4 of tap[b][k]*basis[n-k], using complex multiplication. Samples from before the first one accepted after reset count as zero.
- R5: The output is (sum of the five filter outputs + (c << 14) + 8192) >>> 14.
- R6: An output outside [-32768, 32767] is clamped to the nearest limit.
- R7: While `out_valid` is high and `out_ready` is low, the output data holds steady. Under any backpressure pattern, no sample is lost, duplicated or reordered.
- R8: With `out_ready` held high, an output appears 5 clock edges after its input is accepted. There is never a valid output without an accepted input still outstanding, and at most 6 samples are in flight.
- R9: A write makes `in_ready` low in the next cycle. Samples accepted before the write use the old coefficients, and samples accepted after it use the new ones.
- R10: Address map: tap[b][k] is at b*5+k, with `cfg_data[31:16]` holding I and `cfg_data[15:0]` holding Q. Weight w[b][j] is at 32+3*b+j, taken from `cfg_data[15:0]`. The offset c is at 48, packed like a tap. Writes to other addresses, or to a weight slot with j greater than the branch order index, change nothing.
- R11: A branch history moves forward only on accepted samples. Idle cycles between samples do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample can be accepted |
| in_i | input | 16 | Input in-phase, signed |
| in_q | input | 16 | Input quadrature, signed |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output |
| out_i | output | 16 | Predistorted in-phase, signed |
| out_q | output | 16 | Predistorted quadrature, signed |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 6 | Coefficient address |
| cfg_data | input | 32 | Coefficient value, I in upper half, Q in lower half |

## Verification
The hardest case to reach is a coefficient write that arrives while several samples are held inside a back-pressured pipeline. Each of those samples must still finish with the set it entered under, and the next sample must wait for the swap. The stimulus sends a burst while the consumer's ready is throttled at random, then issues a write between two sends. It confirms that acceptance stops, and the queued expectations pin every output to its own coefficient set. Full-scale inputs, including -32768 on both rails, are also driven together with a large offset, to reach clamping and the widest basis products.

// File: rtl/aph_pkg.sv
package aph_pkg;
  localparam int DW      = 16;            // sample width
  localparam int CW      = 16;            // coefficient width
  localparam int NTAP    = 5;             // taps per branch
  localparam int NMAIN   = 3;             // main branches: orders 1,3,5
  localparam int NCONJ   = 2;             // conjugate branches: orders 1,3
  localparam int NBR     = NMAIN + NCONJ;
  localparam int NORD    = NMAIN;         // weight slots per branch
  localparam int FRAC    = 15;            // unity scale of magnitude terms
  localparam int WFRAC   = 12;            // weight fraction bits
  localparam int TFRAC   = 14;            // tap fraction bits
  localparam int ADDR_W  = 6;

  localparam int MAGW    = 2*DW + 1;
  localparam int EW      = DW + 3;
  localparam int SUMW    = CW + EW + 2;
  localparam int SW      = SUMW - WFRAC;
  localparam int PRODW   = SW + DW + 1;
  localparam int BW      = PRODW - FRAC;
  localparam int ACCW    = BW + CW + 7;

  localparam int NTAPS_ALL = NBR * NTAP;
  localparam int NWT       = NBR * NORD;
  localparam int TAP_BASE  = 0;
  localparam int WT_BASE   = 32;
  localparam int C_ADDR    = 48;
  localparam int SMAX      = (1 << (DW-1)) - 1;
  localparam int SMIN      = -(1 << (DW-1));

  typedef logic signed [DW-1:0]   samp_t;
  typedef logic signed [CW-1:0]   coef_t;
  typedef logic signed [EW-1:0]   mag_t;
  typedef logic signed [BW-1:0]   basis_t;
  typedef logic signed [ACCW-1:0] acc_t;

  // order index inside the branch family (0 -> order 1, 1 -> 3, 2 -> 5)
  function automatic int br_ord(int b);
    return (b < NMAIN) ? b : b - NMAIN;
  endfunction

  function automatic bit br_conj(int b);
    return b >= NMAIN;
  endfunction

  function automatic bit wt_used(int s);
    return (s % NORD) <= br_ord(s / NORD);
  endfunction

  function automatic samp_t round_sat(acc_t a);
    acc_t r;
    r = (a + ACCW'(1 <<< (TFRAC-1))) >>> TFRAC;
    if (r > ACCW'(SMAX)) return samp_t'(SMAX);
    if (r < ACCW'(SMIN)) return samp_t'(SMIN);
    return samp_t'(r);
  endfunction
endpackage

// File: rtl/aph_coef_bank.sv
// Staging and working coefficient copies; staging moves to working when
// the pipeline holds no sample.
module aph_coef_bank
  import aph_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2*CW-1:0]   data,
  input  logic              pipe_empty,
  output logic              pending,
  output coef_t             tap_i [NTAPS_ALL],
  output coef_t             tap_q [NTAPS_ALL],
  output coef_t             wt    [NWT],
  output coef_t             c_i,
  output coef_t             c_q
);
  coef_t st_tap_i [NTAPS_ALL];
  coef_t st_tap_q [NTAPS_ALL];
  coef_t st_wt    [NWT];
  coef_t st_c_i, st_c_q;
  logic  commit;

  assign commit = pending && pipe_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NTAPS_ALL; s++) begin
        st_tap_i[s] <= '0; st_tap_q[s] <= '0;
        tap_i[s]    <= '0; tap_q[s]    <= '0;
      end
      for (int s = 0; s < NWT; s++) begin
        st_wt[s] <= '0; wt[s] <= '0;
      end
      st_c_i <= '0; st_c_q <= '0; c_i <= '0; c_q <= '0;
      pending <= 1'b0;
    end else begin
      if (we) begin
        for (int s = 0; s < NTAPS_ALL; s++)
          if (addr == ADDR_W'(TAP_BASE + s)) begin
            st_tap_i[s] <= coef_t'(data[2*CW-1:CW]);
            st_tap_q[s] <= coef_t'(data[CW-1:0]);
          end
        for (int s = 0; s < NWT; s++)
          if (addr == ADDR_W'(WT_BASE + s) && wt_used(s))
            st_wt[s] <= coef_t'(data[CW-1:0]);
        if (addr == ADDR_W'(C_ADDR)) begin
          st_c_i <= coef_t'(data[2*CW-1:CW]);
          st_c_q <= coef_t'(data[CW-1:0]);
        end
        pending <= 1'b1;
      end else if (commit) begin
        pending <= 1'b0;
      end
      if (commit) begin
        for (int s = 0; s < NTAPS_ALL; s++) begin
          tap_i[s] <= st_tap_i[s]; tap_q[s] <= st_tap_q[s];
        end
        for (int s = 0; s < NWT; s++) wt[s] <= st_wt[s];
        c_i <= st_c_i; c_q <= st_c_q;
      end
    end
  end
endmodule

// File: rtl/aph_basis.sv
// Three stages: |x|^2, then |x|^4 from |x|^2, then per-branch basis values.
module aph_basis
  import aph_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   adv,
  input  logic   vin,
  input  samp_t  xi,
  input  samp_t  xq,
  input  coef_t  wt [NWT],
  output logic   busy,
  output logic   vout,
  output basis_t bi [NBR],
  output basis_t bq [NBR]
);
  localparam mag_t E1 = mag_t'(1 <<< FRAC);

  logic  v1, v2;
  samp_t x1i, x1q, x2i, x2q;
  mag_t  e3_1, e3_2, e5_2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0;
    end else if (adv) begin
      v1 <= vin; v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      x1i  <= xi; x1q <= xq;
      e3_1 <= mag_t'((MAGW'(xi) * MAGW'(xi) + MAGW'(xq) * MAGW'(xq)) >>> FRAC);
      x2i  <= x1i; x2q <= x1q; e3_2 <= e3_1;
      e5_2 <= mag_t'(((2*EW)'(e3_1) * (2*EW)'(e3_1)) >>> FRAC);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vout <= 1'b0;
    else if (adv) vout <= v2;
  end

  for (genvar b = 0; b < NBR; b++) begin : g_br
    localparam int ORD = br_ord(b);
    logic signed [SUMW-1:0] sacc;
    logic signed [SW-1:0]   gain;
    logic signed [DW:0]     ximg;

    always_comb begin
      sacc = SUMW'(wt[b*NORD]) * SUMW'(E1);
      if (ORD >= 1) sacc = sacc + SUMW'(wt[b*NORD+1]) * SUMW'(e3_2);
      if (ORD >= 2) sacc = sacc + SUMW'(wt[b*NORD+2]) * SUMW'(e5_2);
      gain = SW'(sacc >>> WFRAC);
      ximg = br_conj(b) ? -((DW+1)'(x2q)) : (DW+1)'(x2q);
    end

    always_ff @(posedge clk) begin
      if (adv) begin
        bi[b] <= basis_t'((PRODW'(gain) * PRODW'(x2i)) >>> FRAC);
        bq[b] <= basis_t'((PRODW'(gain) * PRODW'(ximg)) >>> FRAC);
      end
    end
  end

  assign busy = v1 | v2 | vout;
endmodule

// File: rtl/aph_branch_fir.sv
// One branch: history of earlier basis values and a complex tap sum.
module aph_branch_fir
  import aph_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   shift,
  input  basis_t cur_i,
  input  basis_t cur_q,
  input  coef_t  tap_i [NTAP],
  input  coef_t  tap_q [NTAP],
  output acc_t   y_i,
  output acc_t   y_q
);
  basis_t hist_i [NTAP-1];
  basis_t hist_q [NTAP-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAP-1; k++) begin
        hist_i[k] <= '0; hist_q[k] <= '0;
      end
    end else if (shift) begin
      hist_i[0] <= cur_i; hist_q[0] <= cur_q;
      for (int k = 1; k < NTAP-1; k++) begin
        hist_i[k] <= hist_i[k-1]; hist_q[k] <= hist_q[k-1];
      end
    end
  end

  always_comb begin
    basis_t vi, vq;
    y_i = '0; y_q = '0;
    for (int k = 0; k < NTAP; k++) begin
      vi = (k == 0) ? cur_i : hist_i[(k == 0) ? 0 : k-1];
      vq = (k == 0) ? cur_q : hist_q[(k == 0) ? 0 : k-1];
      y_i = y_i + ACCW'(tap_i[k]) * ACCW'(vi) - ACCW'(tap_q[k]) * ACCW'(vq);
      y_q = y_q + ACCW'(tap_i[k]) * ACCW'(vq) + ACCW'(tap_q[k]) * ACCW'(vi);
    end
  end
endmodule

// File: rtl/aph_predistorter.sv
module aph_predistorter
  import aph_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_i,
  input  logic [DW-1:0]     in_q,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_i,
  output logic [DW-1:0]     out_q,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [2*CW-1:0]   cfg_data
);
  logic   adv, pending, busy, v0, v3, v4;
  samp_t  x0i, x0q;
  coef_t  tap_i [NTAPS_ALL];
  coef_t  tap_q [NTAPS_ALL];
  coef_t  wt    [NWT];
  coef_t  c_i, c_q;
  basis_t bi [NBR];
  basis_t bq [NBR];
  acc_t   y_i [NBR];
  acc_t   y_q [NBR];
  acc_t   sum_i, sum_q, acc_i, acc_q;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv && !pending;

  aph_coef_bank u_bank (
    .clk, .rst, .we(cfg_we), .addr(cfg_addr), .data(cfg_data),
    .pipe_empty(!(v0 || busy || v4)), .pending,
    .tap_i, .tap_q, .wt, .c_i, .c_q
  );

  always_ff @(posedge clk) begin
    if (rst) v0 <= 1'b0;
    else if (adv) v0 <= in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      x0i <= samp_t'(in_i); x0q <= samp_t'(in_q);
    end
  end

  aph_basis u_basis (
    .clk, .rst, .adv, .vin(v0), .xi(x0i), .xq(x0q), .wt,
    .busy, .vout(v3), .bi, .bq
  );

  for (genvar b = 0; b < NBR; b++) begin : g_fir
    coef_t bt_i [NTAP];
    coef_t bt_q [NTAP];
    always_comb begin
      for (int k = 0; k < NTAP; k++) begin
        bt_i[k] = tap_i[b*NTAP+k];
        bt_q[k] = tap_q[b*NTAP+k];
      end
    end
    aph_branch_fir u_fir (
      .clk, .rst, .shift(adv && v3), .cur_i(bi[b]), .cur_q(bq[b]),
      .tap_i(bt_i), .tap_q(bt_q), .y_i(y_i[b]), .y_q(y_q[b])
    );
  end

  always_comb begin
    sum_i = ACCW'(c_i) <<< TFRAC;
    sum_q = ACCW'(c_q) <<< TFRAC;
    for (int b = 0; b < NBR; b++) begin
      sum_i = sum_i + y_i[b];
      sum_q = sum_q + y_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v4 <= 1'b0; out_valid <= 1'b0;
    end else if (adv) begin
      v4 <= v3; out_valid <= v4;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      acc_i <= sum_i; acc_q <= sum_q;
      out_i <= round_sat(acc_i);
      out_q <= round_sat(acc_q);
    end
  end
endmodule

// File: rtl/aph_predistorter_chk.sv
module aph_predistorter_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_i,
  input logic [15:0] out_q,
  input logic        cfg_we
);
  logic [3:0] inflight;

  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else inflight <= inflight + 4'(in_valid && in_ready) - 4'(out_valid && out_ready);
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !out_valid && in_ready);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q));

  // R8
  no_orphan_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> inflight != 4'd0);

  // R8
  occupancy_chk: assert property (@(posedge clk) disable iff (rst)
    inflight <= 4'd6);

  // R9
  cfg_block_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !in_ready);
endmodule

bind aph_predistorter aph_predistorter_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
  .cfg_we(cfg_we)
);

// File: tb/aph_predistorter_test.sv
module aph_predistorter_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1, cfg_we = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0, out_i, out_q;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;

  aph_predistorter uut (
    .clk, .rst, .in_valid, .in_ready, .in_i, .in_q, .out_valid, .out_ready,
    .out_i, .out_q, .cfg_we, .cfg_addr, .cfg_data
  );

  int checks = 0, errors = 0;
  longint cyc = 0;
  bit bp_on = 0, lat_on = 0, finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { longint ei; longint eq; longint t; string tag; } exp_t;
  exp_t q[$];

  longint m_ti[25], m_tq[25], m_w[15], m_ci = 0, m_cq = 0;
  longint h_i[5][5], h_q[5][5];

  task automatic chk(string req, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Independent integer model of R2-R6
  task automatic model(input longint xi, input longint xq, output longint oi, output longint oq);
    longint e[3];
    longint ai, aq;
    e[0] = 32768;
    e[1] = (xi*xi + xq*xq) >>> 15;
    e[2] = (e[1]*e[1]) >>> 15;
    ai = m_ci <<< 14; aq = m_cq <<< 14;
    for (int b = 0; b < 5; b++) begin
      longint s, xim;
      int ord;
      ord = (b < 3) ? b : b - 3;
      xim = (b < 3) ? xq : -xq;
      s = 0;
      for (int j = 0; j <= ord; j++) s += m_w[b*3+j] * e[j];
      s = s >>> 12;
      for (int k = 4; k > 0; k--) begin h_i[b][k] = h_i[b][k-1]; h_q[b][k] = h_q[b][k-1]; end
      h_i[b][0] = (s*xi) >>> 15;
      h_q[b][0] = (s*xim) >>> 15;
      for (int k = 0; k < 5; k++) begin
        ai += m_ti[b*5+k]*h_i[b][k] - m_tq[b*5+k]*h_q[b][k];
        aq += m_ti[b*5+k]*h_q[b][k] + m_tq[b*5+k]*h_i[b][k];
      end
    end
    oi = sat16((ai + 8192) >>> 14);
    oq = sat16((aq + 8192) >>> 14);
  endtask

  task automatic wr(int a, int di, int dq);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_data = {16'(di), 16'(dq)};
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (a < 25) begin m_ti[a] = longint'(16'(di) & 16'hffff) - ((di & 32'h8000) != 0 ? 65536 : 0);
                      m_tq[a] = longint'(16'(dq) & 16'hffff) - ((dq & 32'h8000) != 0 ? 65536 : 0); end
    else if (a >= 32 && a < 47 && ((a-32) % 3) <= (((a-32)/3 < 3) ? (a-32)/3 : (a-32)/3 - 3))
      m_w[a-32] = longint'(16'(dq) & 16'hffff) - ((dq & 32'h8000) != 0 ? 65536 : 0);
    else if (a == 48) begin m_ci = di; m_cq = dq; end
  endtask

  task automatic send(int xi, int xq, string tag);
    bit acc = 0;
    exp_t e;
    longint oi, oq;
    while (!acc) begin
      @(negedge clk);
      in_valid = 1'b1; in_i = 16'(xi); in_q = 16'(xq);
      #5;
      acc = in_ready;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    model(xi, xq, oi, oq);
    e.ei = oi; e.eq = oq; e.t = cyc; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic int rnd16();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  // out_ready driver
  initial forever begin
    @(negedge clk);
    out_ready = bp_on ? ($urandom_range(2) != 0) : 1'b1;
  end

  // monitor / scoreboard
  initial forever begin
    exp_t e;
    @(negedge clk); #5;
    if (!rst && out_valid && out_ready) begin
      if (q.size() == 0) chk("R8 output without input", 1, 0);
      else begin
        e = q.pop_front();
        chk({e.tag, " I"}, longint'(out_i), e.ei);
        chk({e.tag, " Q"}, longint'(out_q), e.eq);
        if (lat_on) chk("R8 latency", cyc - e.t, 5);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired, actual hung expected done");
    summary();
  end

  initial begin
    for (int s = 0; s < 25; s++) begin m_ti[s] = 0; m_tq[s] = 0; end
    for (int s = 0; s < 15; s++) m_w[s] = 0;
    for (int b = 0; b < 5; b++) for (int k = 0; k < 5; k++) begin h_i[b][k] = 0; h_q[b][k] = 0; end
    void'($urandom(7));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #5;
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 in_ready after reset", in_ready, 1);

    // identity path on main order 1 plus half-weight on one delayed tap
    wr(0, 16384, 0);
    wr(1, 8192, 0);
    wr(32, 0, 4096);
    lat_on = 1;
    send(1000, -2000, "R4 first sample zero history");
    send(3000, 500, "R2 order-1 identity");
    send(-32768, 32767, "R2 full scale");
    drain();
    lat_on = 0;

    // rich set on every branch, plus offset
    for (int b = 0; b < 5; b++)
      for (int k = 0; k < 5; k++)
        wr(b*5+k, ((b*7 + k*3) % 11 - 5) * 700, ((b*5 + k) % 9 - 4) * 500);
    for (int s = 0; s < 15; s++) wr(32+s, 0, ((s*5) % 13 - 6) * 600 + 1500);
    wr(48, 120, -75);
    for (int n = 0; n < 40; n++) send(rnd16() / 2, rnd16() / 2, "R2 R3 R4 R5 mixed");
    bp_on = 1;
    for (int n = 0; n < 40; n++) begin
      send(rnd16(), rnd16(), "R7 backpressure");
      if (n % 5 == 0) repeat (3) @(negedge clk);   // idle gaps, R11
    end
    send(-32768, -32768, "R2 both rails negative");
    drain();
    bp_on = 0;

    // R11: gaps between samples
    for (int n = 0; n < 10; n++) begin
      send(rnd16(), rnd16(), "R11 gapped stream");
      repeat (n % 4) @(negedge clk);
    end
    drain();

    // R3: only conjugate branches active
    for (int s = 0; s < 15; s++) wr(s, 0, 0);
    wr(48, 0, 0);
    wr(15, 16384, 0);
    wr(21, 4000, -3000);
    send(5000, 7000, "R3 conjugate only");
    send(-12000, 9000, "R3 conjugate only");
    drain();

    // R10: ignored writes (unused weight slot, unmapped address)
    wr(34, 0, 30000);
    wr(60, 30000, 30000);
    wr(25, 0, 0);
    for (int n = 0; n < 6; n++) send(rnd16(), rnd16(), "R10 ignored writes");
    drain();

    // R6: clamp with large offset
    wr(48, 32000, -32000);
    wr(0, 32767, 0);
    wr(32, 0, 32767);
    send(30000, -30000, "R6 clamp");
    send(-32768, 32767, "R6 clamp");
    drain();

    // R9: write while samples are held back
    wr(48, 0, 0);
    bp_on = 1;
    for (int n = 0; n < 4; n++) send(rnd16() / 4, rnd16() / 4, "R9 before write");
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'd48; cfg_data = {16'(1000), 16'(-1000)};
    @(posedge clk); #1;
    cfg_we = 1'b0; m_ci = 1000; m_cq = -1000;
    @(negedge clk); #5;
    chk("R9 in_ready low after write", in_ready, 0);
    for (int n = 0; n < 4; n++) send(rnd16() / 4, rnd16() / 4, "R9 after write");
    drain();
    bp_on = 0;

    summary();
  end
endmodule